// File: doc/BRIEF.md
# Decimate-by-2 Phase Alignment Unit

This block reduces one channel of converter samples, arriving one per clock, to half the rate: every second clock it emits one code built from a pair of consecutive samples. Which two samples form a pair is set by an internal divide-by-2 phase. Left alone, that phase depends on when reset ended, so two copies of the block on the same clock may pair (N, N+1) and (N+1, N+2). A shared alignment pulse restarts the phase in every copy at once, after which all copies emit codes built from the same sample pairs.

A route bit decides what the alignment pulse acts on. With the bit low, which is the state straight after reset, the pulse realigns the pairing phase. With the bit high, the pairing phase runs on untouched and the pulse instead restarts a ramp test pattern. The ramp can replace the averaged data on the output when the pattern enable is set. Each code comes with a one-cycle valid strobe and a frame bit that flips once per code.

Top module: `dec2_sync_top`

## Requirements
- R1: At most one code is issued per two clocks; when no realignment occurs, `dout_valid_o` is high on exactly every second cycle.
- R2: With `tp_en_i` low, a code equals the sum of its two paired samples, formed one bit wider than `DW`, shifted right by one with truncation (4095 and 0 give 2047 for `DW` = 12).
- R3: If `sync_i` is first sampled high at clock edge 0, the two samples taken at edges 3 and 4 form the first pair after alignment, and that code is valid after edge 4. Further codes follow after edges 6, 8 and so on.
- R4: A `sync_i` pulse one clock wide is enough. Only the rising edge acts: holding `sync_i` high for many cycles realigns once.
- R5: After reset, with `sync_route_i` = 0, the alignment pulse realigns the pairing phase without any configuration step.
- R6: With `sync_route_i` = 1, the pairing phase ignores `sync_i` and the valid strobe keeps alternating with no gap.
- R7: With `sync_route_i` = 1, a rising edge of `sync_i` restarts the ramp, so the first code issued after the restart carries ramp value 0.
- R8: The ramp advances by 1 with each issued code and wraps from 2^`DW`-1 to 0.
- R9: With `tp_en_i` high, each code is the current ramp value instead of the averaged samples.
- R10: After reset, `dout_o`, `dout_valid_o` and `frame_o` are all 0. `frame_o` inverts in the cycle each code is issued and holds otherwise.
- R11: Two instances on the same clock, with reset released one cycle apart, first pair differently; after a shared `sync_i` pulse they issue identical codes in the same cycles.
- R12: With `sync_route_i` = 0, `sync_i` does not disturb the ramp: consecutive test codes still rise by 1 across the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock, one sample per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sync_i | input | 1 | Asynchronous alignment pulse, rising edge acts |
| sync_route_i | input | 1 | 0: pulse realigns pairing; 1: pulse restarts ramp |
| tp_en_i | input | 1 | 1: output ramp values instead of averages |
| din_i | input | DW | Input sample |
| dout_o | output | DW | Output code |
| dout_valid_o | output | 1 | One-cycle strobe per code |
| frame_o | output | 1 | Inverts with each code |

## Verification
Sample streams are numbered so that every pairing yields a different average. A wrong pairing phase, or an off-by-one alignment latency, therefore shows up as a distinct wrong value. Two copies started one cycle apart expose the unaligned case and then the convergence after a shared pulse. Full-scale and zero samples exercise the carry bit and the truncation. The pulse is applied in both routes at a phase where a realignment would leave a visible gap in the strobe, which separates realigning the pairing from restarting the ramp. A long ramp run covers the wrap.

// File: rtl/dec2_pkg.sv
package dec2_pkg;

    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } dec_phase_e;

    typedef enum logic {
        ROUTE_FILTER = 1'b0,
        ROUTE_RAMP   = 1'b1
    } sync_route_e;

endpackage

// File: rtl/dec2_sync_edge.sv
module dec2_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_i,
    output logic edge_o
);
    localparam int TOP = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
        logic                   last;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[SYNC_STAGES-2:0], sync_i};
        st_d.last  = st_q.chain[TOP];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign edge_o = st_q.chain[TOP] & ~st_q.last;

    // R4
    edge_single_chk: assert property (@(posedge clk) disable iff (rst)
        edge_o |=> !edge_o);

endmodule

// File: rtl/dec2_phase_div.sv
module dec2_phase_div
    import dec2_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sync_edge_i,
    input  sync_route_e route_i,
    output dec_phase_e  phase_o
);
    typedef struct packed {
        dec_phase_e phase;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sync_edge_i && route_i == ROUTE_FILTER)
            st_d.phase = PH_FIRST;
        else if (st_q.phase == PH_FIRST)
            st_d.phase = PH_SECOND;
        else
            st_d.phase = PH_FIRST;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{phase: PH_FIRST};
        else     st_q <= st_d;
    end

    assign phase_o = st_q.phase;

    // R3
    realign_chk: assert property (@(posedge clk) disable iff (rst)
        (sync_edge_i && route_i == ROUTE_FILTER) |=> phase_o == PH_FIRST);

    // R6
    ignore_sync_chk: assert property (@(posedge clk) disable iff (rst)
        (sync_edge_i && route_i == ROUTE_RAMP) |=> phase_o != $past(phase_o));

endmodule

// File: rtl/dec2_ramp_gen.sv
module dec2_ramp_gen
    import dec2_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sync_edge_i,
    input  sync_route_e   route_i,
    input  logic          step_i,
    output logic [DW-1:0] ramp_o
);
    typedef struct packed {
        logic [DW-1:0] value;
    } ramp_st_t;

    ramp_st_t st_d, st_q;
    logic     restart;

    assign restart = sync_edge_i && (route_i == ROUTE_RAMP);

    always_comb begin
        st_d = st_q;
        if (restart)
            st_d.value = '0;
        else if (step_i)
            st_d.value = st_q.value + DW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign ramp_o = st_q.value;

    // R7
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> ramp_o == '0);

    // R8
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (step_i && !restart) |=> ramp_o == $past(ramp_o) + DW'(1));

    // R12
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!step_i && !restart) |=> $stable(ramp_o));

endmodule

// File: rtl/dec2_sync_top.sv
module dec2_sync_top
    import dec2_pkg::*;
#(
    parameter int DW          = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sync_i,
    input  logic          sync_route_i,
    input  logic          tp_en_i,
    input  logic [DW-1:0] din_i,
    output logic [DW-1:0] dout_o,
    output logic          dout_valid_o,
    output logic          frame_o
);
    localparam int SW = DW + 1;

    typedef struct packed {
        logic [DW-1:0] hold;
        logic [DW-1:0] dout;
        logic          valid;
        logic          frame;
    } top_st_t;

    top_st_t     st_d, st_q;
    logic        sync_edge;
    dec_phase_e  phase;
    sync_route_e route;
    logic [DW-1:0] ramp;
    logic [SW-1:0] pair_sum;
    logic          second;

    assign route  = sync_route_e'(sync_route_i);
    assign second = (phase == PH_SECOND);

    dec2_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .sync_i (sync_i),
        .edge_o (sync_edge)
    );

    dec2_phase_div u_div (
        .clk         (clk),
        .rst         (rst),
        .sync_edge_i (sync_edge),
        .route_i     (route),
        .phase_o     (phase)
    );

    dec2_ramp_gen #(.DW(DW)) u_ramp (
        .clk         (clk),
        .rst         (rst),
        .sync_edge_i (sync_edge),
        .route_i     (route),
        .step_i      (second),
        .ramp_o      (ramp)
    );

    assign pair_sum = {1'b0, st_q.hold} + {1'b0, din_i};

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (!second) begin
            st_d.hold = din_i;
        end else begin
            st_d.dout  = tp_en_i ? ramp : pair_sum[SW-1:1];
            st_d.valid = 1'b1;
            st_d.frame = ~st_q.frame;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign dout_o       = st_q.dout;
    assign dout_valid_o = st_q.valid;
    assign frame_o      = st_q.frame;

    // R1
    one_code_per_pair_chk: assert property (@(posedge clk) disable iff (rst)
        dout_valid_o |=> !dout_valid_o);

    // R10
    frame_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        dout_valid_o |-> frame_o != $past(frame_o));

    // R10
    frame_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !dout_valid_o |-> $stable(frame_o));

    // R9
    pattern_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (second && tp_en_i) |=> dout_o == $past(ramp));

endmodule

// File: tb/sim_dec2_sync_top.sv
module sim_dec2_sync_top;
    localparam int DW  = 12;
    localparam int MAX = (1 << DW) - 1;

    logic clk = 1'b0;
    logic rst0 = 1'b1, rst1 = 1'b1;
    logic sync = 1'b0, route = 1'b0, tp = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] d0, d1;
    logic v0, v1, f0, f1;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    dec2_sync_top #(.DW(DW)) u0 (
        .clk(clk), .rst(rst0), .sync_i(sync), .sync_route_i(route),
        .tp_en_i(tp), .din_i(din), .dout_o(d0), .dout_valid_o(v0), .frame_o(f0)
    );

    dec2_sync_top #(.DW(DW)) u1 (
        .clk(clk), .rst(rst1), .sync_i(sync), .sync_route_i(route),
        .tp_en_i(tp), .din_i(din), .dout_o(d1), .dout_valid_o(v1), .frame_o(f1)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_valid();
        for (int i = 0; i < 8 && !v0; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(v0 == 1'b0, "R10 valid in reset", v0, 0);
        chk(d0 == '0, "R10 data in reset", d0, 0);
        chk(f0 == 1'b0, "R10 frame in reset", f0, 0);
        rst0 = 1'b0;
        @(negedge clk);
        rst1 = 1'b0;
        for (int i = 0; i < 6; i++) @(negedge clk);
        chk((v0 ^ v1) == 1'b1, "R11 unaligned before sync", v0 ^ v1, 1);
        @(negedge clk);
        chk((v0 ^ v1) == 1'b1, "R11 unaligned before sync", v0 ^ v1, 1);
    endtask

    task automatic t_sync_align();
        logic fr;
        fr = 1'b0;
        route = 1'b0; tp = 1'b0;
        for (int k = 0; k <= 8; k++) begin
            sync = (k == 0);
            din  = DW'(10 * (k + 1));
            @(negedge clk);
            if (k >= 3) begin
                chk(v0 == (k % 2 == 0), "R3 R5 valid after sync", v0, k % 2 == 0);
                chk(v1 == v0, "R11 valid aligned", v1, v0);
                if (k % 2 == 0) begin
                    chk(d0 == DW'(10 * k + 5), "R3 R2 pair code", d0, 10 * k + 5);
                    chk(d1 == d0, "R11 same code", d1, d0);
                end
            end
            if (k == 4) fr = f0;
            if (k == 5) chk(f0 == fr, "R10 frame holds", f0, fr);
            if (k == 6) chk(f0 != fr, "R10 frame toggles", f0, !fr);
        end
    endtask

    task automatic t_long_sync();
        route = 1'b0; tp = 1'b0;
        for (int k = 0; k <= 14; k++) begin
            sync = (k < 10);
            din  = DW'(k);
            @(negedge clk);
            if (k >= 3)
                chk(v0 == (k % 2 == 0), "R4 single realign on held sync", v0, k % 2 == 0);
        end
        sync = 1'b0;
    endtask

    task automatic t_avg_edges();
        route = 1'b0; tp = 1'b0;
        for (int k = 0; k <= 6; k++) begin
            sync = (k == 0);
            case (k)
                3:       din = DW'(MAX);
                4:       din = '0;
                5:       din = DW'(MAX);
                6:       din = DW'(MAX - 1);
                default: din = '0;
            endcase
            @(negedge clk);
            if (k == 4) chk(d0 == DW'(MAX / 2), "R2 full scale plus zero", d0, MAX / 2);
            if (k == 6) chk(d0 == DW'(MAX - 1), "R2 carry and truncation", d0, MAX - 1);
        end
        sync = 1'b0;
    endtask

    task automatic t_ramp_route();
        wait_valid();
        chk(v0 == 1'b1, "R1 valid found", v0, 1);
        route = 1'b1; tp = 1'b1; sync = 1'b1;
        for (int j = 1; j <= 12; j++) begin
            @(negedge clk);
            sync = 1'b0;
            chk(v0 == (j % 2 == 0), "R6 R1 no realign in ramp route", v0, j % 2 == 0);
            if (j >= 4 && j % 2 == 0)
                chk(d0 == DW'((j - 4) / 2), "R7 R8 R9 ramp after restart", d0, (j - 4) / 2);
        end
    endtask

    task automatic t_ramp_ignores_sync();
        int r;
        int got;
        route = 1'b0; tp = 1'b1;
        wait_valid();
        r = int'(d0);
        sync = 1'b1;
        @(negedge clk);
        sync = 1'b0;
        got = 0;
        for (int i = 0; i < 20 && got < 4; i++) begin
            @(negedge clk);
            if (v0) begin
                got++;
                chk(int'(d0) == ((r + got) & MAX), "R12 ramp continues", d0, (r + got) & MAX);
            end
        end
        chk(got == 4, "R12 codes seen", got, 4);
    endtask

    task automatic t_wrap();
        int prev;
        bit done;
        route = 1'b1; tp = 1'b1; sync = 1'b1;
        @(negedge clk);
        sync = 1'b0;
        prev = -1;
        done = 1'b0;
        for (int i = 0; i < 10000 && !done; i++) begin
            @(negedge clk);
            if (v0) begin
                if (prev == MAX) begin
                    chk(d0 == '0, "R8 ramp wraps", d0, 0);
                    done = 1'b1;
                end
                prev = int'(d0);
            end
        end
        chk(done, "R8 wrap reached", done, 1);
        route = 1'b0; tp = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_sync_align();
        t_long_sync();
        t_avg_edges();
        t_ramp_route();
        t_ramp_ignores_sync();
        t_wrap();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule